// File: doc/BRIEF.md
# Page Column Pointer Controller

This block holds the byte column pointer of a page buffer for a page-oriented flash array. Three read commands pick one of three page regions: the lower half of the main area, the upper half of the main area, or the small spare area at the end of the page. A column byte that is latched after the command then places the pointer inside the chosen region. Each falling edge of the read enable moves the pointer forward by one byte. At the last byte of the page the pointer stops advancing. One more falling edge then raises a one-cycle request for the next page and holds the pointer until that page is reported as loaded. After the load, the pointer restarts at a position that depends on the region, so the host can read page after page without issuing new commands.

A static option bit selects pages of 528 bytes (512 main plus 16 spare) or of 512 bytes. In 512-byte mode the spare region does not exist. The block only tracks the pointer and the region. Fetching from the array and returning data bytes are done elsewhere.

Top module: `page_col_ptr`

## Requirements
- R1: After reset the column is 0, the region code is 0 (lower main), and both `next_page_req` and `page_wait` are low.
- R2: A lower-main command sets region code 0 and column 0. A following column load sets the column to the column byte (0 to 255).
- R3: An upper-main command sets region code 1 and column 256. A following column load sets the column to 256 plus the column byte.
- R4: A spare command sets region code 2 and column 512. A following column load sets the column to 512 plus bits 3:0 of the column byte, and bits 7:4 are ignored. While the region is 2, the column always lies in 512..527.
- R5: When `small_page` is 1, a spare command has no effect: region and column stay unchanged.
- R6: In read mode, with no page pending, each `re_fall` pulse adds exactly 1 to the column while the column is below the last column. After a read-exit strobe, `re_fall` leaves the column unchanged.
- R7: A `re_fall` pulse at the last column leaves the column unchanged, pulses `next_page_req` high for exactly one cycle and sets `page_wait`. While `page_wait` is high, further `re_fall` pulses change neither the column nor the request.
- R8: A `page_ready` pulse while `page_wait` is high clears `page_wait`. In region 0 or 1 the column goes to 0 and the region becomes 0. In region 2 the column goes to 512 and the region stays 2.
- R9: Region 2 is left only by a lower-main command. An upper-main command while in region 2 has no effect.
- R10: The last column is 527 when `small_page` is 0 and 511 when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| small_page | input | 1 | 1 selects 512-byte pages, 0 selects 528-byte pages |
| cmd_main_lo | input | 1 | Strobe: lower-main read command |
| cmd_main_hi | input | 1 | Strobe: upper-main read command |
| cmd_spare | input | 1 | Strobe: spare-area read command |
| cmd_exit | input | 1 | Strobe: a non-read command ends read mode |
| col_load | input | 1 | Strobe: column byte is valid |
| col_byte | input | 8 | Latched column address byte |
| re_fall | input | 1 | One-cycle pulse per read-enable falling edge |
| page_ready | input | 1 | Strobe: next page is in the buffer |
| col | output | 10 | Current column pointer |
| next_page_req | output | 1 | One-cycle request to fetch the next page |
| region | output | 2 | Region code: 0 lower main, 1 upper main, 2 spare |
| page_wait | output | 1 | A next-page fetch is pending |

## Verification
The assertions check the following on every cycle: the single-step advance of the pointer, the freeze of the pointer and the request while a page is pending, the one-cycle width of the request, the spare-window bound, the stickiness of the spare region, and the refusal of the spare region in small-page mode. The bench scenarios cover what needs absolute values or long histories: the start offsets of each region, masking of the high nibble, the wrap targets after a page load, the two last-column limits, and inertness after a read exit. The randomized walks cover many starting offsets and run lengths per region.

// File: rtl/pcp_pkg.sv
package pcp_pkg;
  typedef enum logic [1:0] {
    RG_LO    = 2'd0,
    RG_HI    = 2'd1,
    RG_SPARE = 2'd2
  } region_e;
endpackage

// File: rtl/pcp_region.sv
module pcp_region
  import pcp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    small_page,
  input  logic    cmd_main_lo,
  input  logic    cmd_main_hi,
  input  logic    cmd_spare,
  input  logic    wrap_acc,
  output region_e rg_q,
  output region_e rg_d,
  output logic    cmd_acc
);

  // next-state: lower-main wins, spare is sticky against upper-main
  always_comb begin
    rg_d    = rg_q;
    cmd_acc = 1'b0;
    if (cmd_main_lo) begin
      rg_d    = RG_LO;
      cmd_acc = 1'b1;
    end else if (cmd_main_hi && (rg_q != RG_SPARE)) begin
      rg_d    = RG_HI;
      cmd_acc = 1'b1;
    end else if (cmd_spare && !small_page) begin
      rg_d    = RG_SPARE;
      cmd_acc = 1'b1;
    end else if (wrap_acc && (rg_q == RG_HI)) begin
      rg_d    = RG_LO;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rg_q <= RG_LO;
    else        rg_q <= rg_d;
  end

  // R9: spare region only left through the lower-main command
  p_spare_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rg_q == RG_SPARE) && !cmd_main_lo |=> (rg_q == RG_SPARE));

  // R5: small pages never enter the spare region
  p_small_no_spare_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rg_q != RG_SPARE) && small_page |=> (rg_q != RG_SPARE));

endmodule

// File: rtl/pcp_counter.sv
module pcp_counter
  import pcp_pkg::*;
#(
  parameter int COL_W    = 10,
  parameter int BYTE_W   = 8,
  parameter int MAIN_SZ  = 512,
  parameter int SPARE_SZ = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              small_page,
  input  logic              cmd_acc,
  input  logic              cmd_exit,
  input  logic              col_load,
  input  logic [BYTE_W-1:0] col_byte,
  input  logic              re_fall,
  input  logic              page_ready,
  input  region_e           rg_q,
  input  region_e           rg_d,
  output logic              wrap_acc,
  output logic [COL_W-1:0]  col_q,
  output logic              req_q,
  output logic              wait_q
);

  localparam int HALF       = MAIN_SZ / 2;
  localparam int SP_W       = $clog2(SPARE_SZ);
  localparam int LAST_BIG   = MAIN_SZ + SPARE_SZ - 1;
  localparam int LAST_SMALL = MAIN_SZ - 1;

  logic [COL_W-1:0] col_d, last_col, cmd_base, load_val;
  logic             mode_q, mode_d, wait_d, req_d, step_ok;

  assign last_col = small_page ? COL_W'(LAST_SMALL) : COL_W'(LAST_BIG);

  always_comb begin
    case (rg_d)
      RG_HI:    cmd_base = COL_W'(HALF);
      RG_SPARE: cmd_base = COL_W'(MAIN_SZ);
      default:  cmd_base = '0;
    endcase
    case (rg_q)
      RG_HI:    load_val = COL_W'(HALF) + COL_W'(col_byte);
      RG_SPARE: load_val = COL_W'(MAIN_SZ) + COL_W'(col_byte[SP_W-1:0]);
      default:  load_val = COL_W'(col_byte);
    endcase
  end

  assign wrap_acc = page_ready && wait_q && !cmd_acc && !cmd_exit && !col_load;
  assign step_ok  = re_fall && mode_q && !wait_q && !cmd_acc && !cmd_exit &&
                    !col_load && !page_ready;

  always_comb begin
    col_d  = col_q;
    mode_d = mode_q;
    wait_d = wait_q;
    req_d  = 1'b0;
    if (cmd_acc) begin
      col_d  = cmd_base;
      mode_d = 1'b1;
      wait_d = 1'b0;
    end else if (cmd_exit) begin
      mode_d = 1'b0;
      wait_d = 1'b0;
    end else if (col_load) begin
      col_d  = load_val;
      wait_d = 1'b0;
    end else if (wrap_acc) begin
      col_d  = (rg_q == RG_SPARE) ? COL_W'(MAIN_SZ) : '0;
      wait_d = 1'b0;
    end else if (step_ok) begin
      if (col_q == last_col) begin
        req_d  = 1'b1;
        wait_d = 1'b1;
      end else begin
        col_d = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      mode_q <= 1'b0;
      wait_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      col_q  <= col_d;
      mode_q <= mode_d;
      wait_q <= wait_d;
      req_q  <= req_d;
    end
  end

  // R6: one step per accepted read strobe below the last column
  p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_ok && (col_q != last_col) |=> col_q == $past(col_q) + 1'b1);

  // R7: pending page freezes pointer and request
  p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q && !cmd_acc && !cmd_exit && !col_load && !page_ready
    |=> $stable(col_q) && !req_q);

  // R7: request lasts one cycle
  p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);

  // R10: pointer never beyond the largest page
  p_col_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= COL_W'(LAST_BIG));

endmodule

// File: rtl/page_col_ptr.sv
module page_col_ptr
  import pcp_pkg::*;
#(
  parameter int COL_W    = 10,
  parameter int BYTE_W   = 8,
  parameter int MAIN_SZ  = 512,
  parameter int SPARE_SZ = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              small_page,
  input  logic              cmd_main_lo,
  input  logic              cmd_main_hi,
  input  logic              cmd_spare,
  input  logic              cmd_exit,
  input  logic              col_load,
  input  logic [BYTE_W-1:0] col_byte,
  input  logic              re_fall,
  input  logic              page_ready,
  output logic [COL_W-1:0]  col,
  output logic              next_page_req,
  output logic [1:0]        region,
  output logic              page_wait
);

  region_e rg_q, rg_d;
  logic    cmd_acc, wrap_acc;

  pcp_region u_region (
    .clk         (clk),
    .rst_n       (rst_n),
    .small_page  (small_page),
    .cmd_main_lo (cmd_main_lo),
    .cmd_main_hi (cmd_main_hi),
    .cmd_spare   (cmd_spare),
    .wrap_acc    (wrap_acc),
    .rg_q        (rg_q),
    .rg_d        (rg_d),
    .cmd_acc     (cmd_acc)
  );

  pcp_counter #(
    .COL_W    (COL_W),
    .BYTE_W   (BYTE_W),
    .MAIN_SZ  (MAIN_SZ),
    .SPARE_SZ (SPARE_SZ)
  ) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .small_page (small_page),
    .cmd_acc    (cmd_acc),
    .cmd_exit   (cmd_exit),
    .col_load   (col_load),
    .col_byte   (col_byte),
    .re_fall    (re_fall),
    .page_ready (page_ready),
    .rg_q       (rg_q),
    .rg_d       (rg_d),
    .wrap_acc   (wrap_acc),
    .col_q      (col),
    .req_q      (next_page_req),
    .wait_q     (page_wait)
  );

  assign region = rg_q;

  // R4: spare region keeps the pointer in the spare window
  p_spare_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rg_q == RG_SPARE) |-> (col >= COL_W'(MAIN_SZ)) &&
                           (col <= COL_W'(MAIN_SZ + SPARE_SZ - 1)));

endmodule

// File: tb/page_col_ptr_test.sv
module page_col_ptr_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       small_page, cmd_main_lo, cmd_main_hi, cmd_spare, cmd_exit;
  logic       col_load, re_fall, page_ready;
  logic [7:0] col_byte;
  logic [9:0] col;
  logic       next_page_req, page_wait;
  logic [1:0] region;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  page_col_ptr uut (
    .clk(clk), .rst_n(rst_n), .small_page(small_page),
    .cmd_main_lo(cmd_main_lo), .cmd_main_hi(cmd_main_hi),
    .cmd_spare(cmd_spare), .cmd_exit(cmd_exit), .col_load(col_load),
    .col_byte(col_byte), .re_fall(re_fall), .page_ready(page_ready),
    .col(col), .next_page_req(next_page_req), .region(region),
    .page_wait(page_wait)
  );

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic int start_col(input int rg, input int b);
    if (rg == 2) return 512 + (b % 16);
    if (rg == 1) return 256 + b;
    return b;
  endfunction

  function automatic int last_of(input bit sp);
    return sp ? 511 : 527;
  endfunction

  // all tasks start and end at a falling clock edge
  task automatic cmd(input int k);
    cmd_main_lo = (k == 0);
    cmd_main_hi = (k == 1);
    cmd_spare   = (k == 2);
    cmd_exit    = (k == 3);
    @(negedge clk);
    cmd_main_lo = 0; cmd_main_hi = 0; cmd_spare = 0; cmd_exit = 0;
  endtask

  task automatic load(input int b);
    col_byte = 8'(b); col_load = 1;
    @(negedge clk);
    col_load = 0;
  endtask

  task automatic reads(input int n);
    for (int i = 0; i < n; i++) begin
      re_fall = 1;
      @(negedge clk);
      re_fall = 0;
    end
  endtask

  task automatic ready();
    page_ready = 1;
    @(negedge clk);
    page_ready = 0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=%0d exp=%0d", 0, 1);
      summary();
    end
  end

  initial begin
    rst_n = 0; small_page = 0; cmd_main_lo = 0; cmd_main_hi = 0;
    cmd_spare = 0; cmd_exit = 0; col_load = 0; re_fall = 0;
    page_ready = 0; col_byte = 0;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 col", col, 0);
    chk("R1 region", region, 0);
    chk("R1 req", next_page_req, 0);
    chk("R1 wait", page_wait, 0);

    // R2 lower main
    cmd(0);
    chk("R2 region", region, 0);
    chk("R2 cmd col", col, 0);
    load(8'h37);
    chk("R2 load col", col, 8'h37);
    reads(3);
    chk("R6 step", col, 8'h3A);

    // R3 upper main, then walk to the end of a large page
    cmd(1);
    chk("R3 region", region, 1);
    chk("R3 cmd col", col, 256);
    load(8'h10);
    chk("R3 load col", col, 272);
    load(8'hFF);
    chk("R3 load max", col, 511);
    reads(16);
    chk("R10 last big", col, 527);
    chk("R7 no early req", next_page_req, 0);
    reads(1);
    chk("R7 hold col", col, 527);
    chk("R7 req", next_page_req, 1);
    chk("R7 wait", page_wait, 1);
    @(negedge clk);
    chk("R7 req one cycle", next_page_req, 0);
    reads(2);
    chk("R7 frozen col", col, 527);
    chk("R7 no re-req", next_page_req, 0);
    ready();
    chk("R8 hi wrap col", col, 0);
    chk("R8 hi wrap region", region, 0);
    chk("R8 wait clr", page_wait, 0);

    // R4 spare, R9 stickiness
    cmd(2);
    chk("R4 region", region, 2);
    chk("R4 cmd col", col, 512);
    load(8'hA5);
    chk("R4 nibble", col, 517);
    cmd(1);
    chk("R9 hi ignored region", region, 2);
    chk("R9 hi ignored col", col, 517);
    reads(10);
    chk("R4 spare end", col, 527);
    reads(1);
    chk("R7 spare req", next_page_req, 1);
    ready();
    chk("R8 spare col", col, 512);
    chk("R8 spare region", region, 2);
    cmd(0);
    chk("R9 leave spare", region, 0);

    // R5 and R10 with small pages
    small_page = 1;
    load(8'h21);
    cmd(2);
    chk("R5 region", region, 0);
    chk("R5 col", col, 8'h21);
    cmd(1);
    load(8'hFE);
    reads(1);
    chk("R10 small last", col, 511);
    reads(1);
    chk("R10 small hold", col, 511);
    chk("R10 small req", next_page_req, 1);
    ready();
    chk("R8 small wrap", col, 0);

    // R6 exit makes reads inert
    load(8'h44);
    cmd(3);
    reads(4);
    chk("R6 exit inert", col, 8'h44);
    small_page = 0;

    // random walks per region
    for (int it = 0; it < 40; it++) begin
      int rg, b, s, n;
      rg = $urandom % 3;
      b  = $urandom % 256;
      cmd(0);
      cmd(rg);
      load(b);
      s = start_col(rg, b);
      chk("R2 R3 R4 rand start", col, s);
      n = $urandom % (last_of(0) - s + 1);
      if (n > 60) n = n % 60;
      reads(n);
      chk("R6 rand walk", col, s + n);
      chk("R6 rand region", region, rg);
      chk("R7 rand no req", next_page_req, 0);
    end

    done = 1'b1;
    summary();
  end

endmodule